// File: doc/BRIEF.md
# SMBus Clock-Low Timeout Guard

This block sits beside the protocol engine of an SMBus slave and keeps a stuck clock from hanging it. Both raw bus lines pass through a two-flop synchroniser and a stability filter that discards spikes shorter than about 100 ns. The block then reports START and STOP conditions as single-cycle strobes. It exposes the cleaned line levels so the protocol engine can use them directly.

A START opens a transaction window and a STOP closes it. Inside the window, a counter measures how long the filtered clock stays low without a break. Every falling clock edge clears the counter. While the clock is high the counter holds its value. When the low time reaches the configured limit (by default 30 ms of system clock, inside the 25 to 35 ms window), the block does two things. It emits a one-cycle reset pulse for the protocol engine. It also stops passing the engine's SDA pull-down request to the pad driver. The release stays in force, and the window stays closed, until the next valid START. Clocks between 10 kHz and 400 kHz never come near the limit, so they cannot trip it.

Top module: `smbus_lowtime_guard`

## Requirements
- R1: Each raw line goes through two synchroniser flops and then a filter. The filtered level takes a new value only after the synchronised level has differed from it on FILTER_CYCLES consecutive clocks. A clean level change on a raw input therefore appears on the filtered output FILTER_CYCLES+2 clocks after it is first sampled.
- R2: A raw pulse shorter than FILTER_CYCLES clocks never reaches the filtered output, and it neither produces a strobe nor restarts the low-time counter.
- R3: `startStrobe` is high for one clock when filtered SDA goes from 1 to 0 while filtered SCL is 1 in both that clock and the clock before. `stopStrobe` is the same for SDA going from 0 to 1.
- R4: With no transaction open (after reset, after a STOP or after a timeout), SCL low time is not measured and `timeoutRst` stays 0 however long SCL is low.
- R5: Only continuous low time counts. Every falling edge of filtered SCL restarts the measurement, and the count holds while SCL is high.
- R6: `timeoutRst` is a single-cycle pulse. It is high in the clock TIMEOUT_CYCLES+1 clocks after the first clock in which filtered SCL reads low inside an open transaction, counting the falling-edge clock as clock 0.
- R7: After a timeout, the transaction window is closed and SDA stays released until the next START. A START seen while a window is already open keeps the window open.
- R8: `sdaDriveLow` equals `slaveSdaLow` whenever the release set by R7 is not in force, and it is 0 while the release is in force.
- R9: After reset, both filtered lines read 1, both strobes and `timeoutRst` read 0, and the release is not in force.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclIn | input | 1 | Raw SCL level from the pad |
| sdaIn | input | 1 | Raw SDA level from the pad |
| slaveSdaLow | input | 1 | Protocol engine asks to pull SDA low |
| sclFilt | output | 1 | Synchronised, spike-filtered SCL |
| sdaFilt | output | 1 | Synchronised, spike-filtered SDA |
| startStrobe | output | 1 | One-clock START indication |
| stopStrobe | output | 1 | One-clock STOP indication |
| timeoutRst | output | 1 | One-clock reset pulse to the protocol engine on timeout |
| sdaDriveLow | output | 1 | Gated SDA pull-down to the pad driver |

## Verification
The bench holds SCL low for far longer than the limit while the bus is idle. A design that armed outside a transaction would fire a reset there. It sends clock bursts whose low phases stay just under the limit, and it splits a long low period with a genuine high phase. A counter that accumulated across pulses, instead of restarting on each falling edge, would time out on these. It splits another long low period with a two-clock spike. A filter that let the spike through would restart the counter and miss the timeout. After a timeout it checks that further low time produces no second pulse and that SDA stays released until a new START, not merely until the clock rises again.

// File: rtl/smbto_pkg.sv
package smbto_pkg;

  // Strobes from the control FSM to the low-time counter in the datapath.
  typedef struct packed {
    logic cntClear;  // zero the low-time counter this clock
    logic cntRun;    // count this clock (window open and SCL low)
  } tmrCtl_t;

  typedef enum logic {
    BUS_IDLE = 1'b0,
    BUS_OPEN = 1'b1
  } busState_t;

endpackage

// File: rtl/smbto_glitch_filter.sv
module smbto_glitch_filter #(
  parameter int unsigned FILTER_CYCLES = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic rawLevel,
  output logic cleanLevel
);

  localparam int unsigned CW = (FILTER_CYCLES < 2) ? 1 : $clog2(FILTER_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(FILTER_CYCLES - 1);

  logic [1:0]    syncQ;
  logic [CW-1:0] holdCnt;
  logic          syncLevel;

  assign syncLevel = syncQ[1];

  // Two-flop synchroniser; idle bus level is high.
  always_ff @(posedge clk) begin
    if (rst) syncQ <= 2'b11;
    else     syncQ <= {syncQ[0], rawLevel};
  end

  // Accept a new level only after it has persisted FILTER_CYCLES clocks.
  always_ff @(posedge clk) begin
    if (rst) begin
      cleanLevel <= 1'b1;
      holdCnt    <= '0;
    end else if (syncLevel == cleanLevel) begin
      holdCnt <= '0;
    end else if (holdCnt == LAST) begin
      cleanLevel <= syncLevel;
      holdCnt    <= '0;
    end else begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  assert_filter_follows_R1: assert property (@(posedge clk) disable iff (rst)
    (cleanLevel != $past(cleanLevel)) |-> (cleanLevel == $past(syncLevel)));

  assert_filter_persist_R2: assert property (@(posedge clk) disable iff (rst)
    (cleanLevel != $past(cleanLevel)) |-> ($past(holdCnt) == LAST));

endmodule

// File: rtl/smbto_datapath.sv
module smbto_datapath
  import smbto_pkg::*;
#(
  parameter int unsigned FILTER_CYCLES  = 25,
  parameter int unsigned TIMEOUT_CYCLES = 7_500_000
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    sclRaw,
  input  logic    sdaRaw,
  input  tmrCtl_t ctl,
  output logic    sclFilt,
  output logic    sdaFilt,
  output logic    sclFall,
  output logic    startDet,
  output logic    stopDet,
  output logic    lowExpired
);

  localparam int unsigned LINES = 2;
  localparam int unsigned CNTW  = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNTW-1:0] CNT_LAST = CNTW'(TIMEOUT_CYCLES - 1);
  localparam logic [CNTW-1:0] CNT_SAT  = CNTW'(TIMEOUT_CYCLES);

  logic [LINES-1:0] rawLines;
  logic [LINES-1:0] cleanLines;
  logic             prevScl;
  logic             prevSda;
  logic [CNTW-1:0]  lowCnt;

  assign rawLines = {sdaRaw, sclRaw};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    smbto_glitch_filter #(
      .FILTER_CYCLES(FILTER_CYCLES)
    ) u_filter (
      .clk       (clk),
      .rst       (rst),
      .rawLevel  (rawLines[g]),
      .cleanLevel(cleanLines[g])
    );
  end

  assign sclFilt = cleanLines[0];
  assign sdaFilt = cleanLines[1];

  // Previous filtered levels for edge and condition detection.
  always_ff @(posedge clk) begin
    if (rst) begin
      prevScl <= 1'b1;
      prevSda <= 1'b1;
    end else begin
      prevScl <= sclFilt;
      prevSda <= sdaFilt;
    end
  end

  assign sclFall  = prevScl & ~sclFilt;
  assign startDet = prevScl & sclFilt & prevSda & ~sdaFilt;
  assign stopDet  = prevScl & sclFilt & ~prevSda & sdaFilt;

  // Continuous low-time counter; holds when not running.
  always_ff @(posedge clk) begin
    if (rst) begin
      lowCnt <= '0;
    end else if (ctl.cntClear) begin
      lowCnt <= '0;
    end else if (ctl.cntRun && (lowCnt != CNT_SAT)) begin
      lowCnt <= lowCnt + 1'b1;
    end
  end

  assign lowExpired = ctl.cntRun & ~ctl.cntClear & (lowCnt == CNT_LAST);

  assert_expire_only_low_R5: assert property (@(posedge clk) disable iff (rst)
    lowExpired |-> !sclFilt);

  assert_count_holds_high_R5: assert property (@(posedge clk) disable iff (rst)
    (!ctl.cntClear && sclFilt) |=> $stable(lowCnt));

  assert_start_shape_R3: assert property (@(posedge clk) disable iff (rst)
    startDet |-> (sclFilt && $past(sclFilt) && $past(sdaFilt) && !sdaFilt));

  assert_stop_shape_R3: assert property (@(posedge clk) disable iff (rst)
    stopDet |-> (sclFilt && $past(sclFilt) && !$past(sdaFilt) && sdaFilt));

endmodule

// File: rtl/smbto_control.sv
module smbto_control
  import smbto_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    sclFilt,
  input  logic    sclFall,
  input  logic    startDet,
  input  logic    stopDet,
  input  logic    lowExpired,
  input  logic    slaveSdaLow,
  output tmrCtl_t ctl,
  output logic    timeoutRst,
  output logic    sdaDriveLow
);

  busState_t busState;
  logic      sdaReleased;
  logic      isOpen;

  assign isOpen = (busState == BUS_OPEN);

  // Timer strobes: count only inside an open window while SCL is low,
  // restart on each falling edge.
  assign ctl.cntClear = ~isOpen | sclFall;
  assign ctl.cntRun   = isOpen & ~sclFilt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busState <= BUS_IDLE;
    end else begin
      unique case (busState)
        BUS_IDLE: if (startDet) busState <= BUS_OPEN;
        BUS_OPEN: if (lowExpired || stopDet) busState <= BUS_IDLE;
        default:  busState <= BUS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      timeoutRst  <= 1'b0;
      sdaReleased <= 1'b0;
    end else begin
      timeoutRst <= isOpen & lowExpired;
      if (startDet)        sdaReleased <= 1'b0;
      else if (lowExpired) sdaReleased <= 1'b1;
    end
  end

  assign sdaDriveLow = slaveSdaLow & ~sdaReleased;

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    timeoutRst |=> !timeoutRst);

  assert_pulse_needs_window_R4: assert property (@(posedge clk) disable iff (rst)
    timeoutRst |-> ($past(busState) == BUS_OPEN));

  assert_closed_after_tmo_R7: assert property (@(posedge clk) disable iff (rst)
    timeoutRst |-> (busState == BUS_IDLE));

  assert_released_on_tmo_R8: assert property (@(posedge clk) disable iff (rst)
    timeoutRst |-> !sdaDriveLow);

endmodule

// File: rtl/smbus_lowtime_guard.sv
module smbus_lowtime_guard
  import smbto_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ    = 250_000_000,
  parameter int unsigned FILTER_NS      = 100,
  parameter int unsigned TIMEOUT_US     = 30_000,
  parameter int unsigned FILTER_CYCLES  =
    int'((longint'(FILTER_NS) * longint'(CLK_FREQ_HZ) + 64'd999_999_999) / 64'd1_000_000_000),
  parameter int unsigned TIMEOUT_CYCLES =
    int'((longint'(TIMEOUT_US) * longint'(CLK_FREQ_HZ)) / 64'd1_000_000)
) (
  input  logic clk,
  input  logic rst,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic slaveSdaLow,
  output logic sclFilt,
  output logic sdaFilt,
  output logic startStrobe,
  output logic stopStrobe,
  output logic timeoutRst,
  output logic sdaDriveLow
);

  tmrCtl_t ctl;
  logic    sclFall;
  logic    lowExpired;

  smbto_datapath #(
    .FILTER_CYCLES (FILTER_CYCLES),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) u_datapath (
    .clk       (clk),
    .rst       (rst),
    .sclRaw    (sclIn),
    .sdaRaw    (sdaIn),
    .ctl       (ctl),
    .sclFilt   (sclFilt),
    .sdaFilt   (sdaFilt),
    .sclFall   (sclFall),
    .startDet  (startStrobe),
    .stopDet   (stopStrobe),
    .lowExpired(lowExpired)
  );

  smbto_control u_control (
    .clk        (clk),
    .rst        (rst),
    .sclFilt    (sclFilt),
    .sclFall    (sclFall),
    .startDet   (startStrobe),
    .stopDet    (stopStrobe),
    .lowExpired (lowExpired),
    .slaveSdaLow(slaveSdaLow),
    .ctl        (ctl),
    .timeoutRst (timeoutRst),
    .sdaDriveLow(sdaDriveLow)
  );

endmodule

// File: tb/test_smbus_lowtime_guard.sv
module test_smbus_lowtime_guard;

  localparam int FILT = 4;
  localparam int TMO  = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclIn = 1'b1;
  logic sdaIn = 1'b1;
  logic slaveSdaLow = 1'b0;
  logic sclFilt, sdaFilt, startStrobe, stopStrobe, timeoutRst, sdaDriveLow;

  always #2 clk = ~clk;  // 250 MHz

  smbus_lowtime_guard #(
    .FILTER_CYCLES (FILT),
    .TIMEOUT_CYCLES(TMO)
  ) i_smbus_lowtime_guard (
    .clk(clk), .rst(rst), .sclIn(sclIn), .sdaIn(sdaIn),
    .slaveSdaLow(slaveSdaLow), .sclFilt(sclFilt), .sdaFilt(sdaFilt),
    .startStrobe(startStrobe), .stopStrobe(stopStrobe),
    .timeoutRst(timeoutRst), .sdaDriveLow(sdaDriveLow)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  int tmoCount = 0;
  int startCount = 0;
  bit sdaLowSeen = 1'b0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference model, advanced on each rising edge.
  int sclQ[$];
  int sdaQ[$];
  int mSclF, mSdaF, mPrevScl, mPrevSda, mSclRun, mSdaRun;
  int mOpen, mLowCnt, mTmo, mReleased;

  function automatic void filterStep(int s2, ref int level, ref int run);
    if (s2 == level) run = 0;
    else begin
      run++;
      if (run == FILT) begin
        level = s2;
        run = 0;
      end
    end
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      sclQ = '{1, 1}; sdaQ = '{1, 1};
      mSclF = 1; mSdaF = 1; mPrevScl = 1; mPrevSda = 1;
      mSclRun = 0; mSdaRun = 0; mOpen = 0; mLowCnt = 0; mTmo = 0; mReleased = 0;
    end else begin
      int fallNow, startNow, stopNow, expire;
      fallNow  = (mPrevScl == 1 && mSclF == 0);
      startNow = (mPrevScl == 1 && mSclF == 1 && mPrevSda == 1 && mSdaF == 0);
      stopNow  = (mPrevScl == 1 && mSclF == 1 && mPrevSda == 0 && mSdaF == 1);
      expire   = (mOpen == 1 && mSclF == 0 && !fallNow && mLowCnt == TMO - 1);
      mTmo = expire;
      if (startNow) mReleased = 0;
      else if (expire) mReleased = 1;
      if (mOpen == 0 || fallNow) mLowCnt = 0;
      else if (mSclF == 0) mLowCnt++;
      if (mOpen == 0) mOpen = startNow;
      else if (expire || stopNow) mOpen = 0;
      mPrevScl = mSclF;
      mPrevSda = mSdaF;
      filterStep(sclQ[0], mSclF, mSclRun);
      filterStep(sdaQ[0], mSdaF, mSdaRun);
      sclQ.push_back(int'(sclIn)); void'(sclQ.pop_front());
      sdaQ.push_back(int'(sdaIn)); void'(sdaQ.pop_front());
    end
  end

  // Compare against the model every clock, away from the active edge.
  always @(negedge clk) begin
    if (!rst && !finished) begin
      int eStart, eStop;
      eStart = (mPrevScl == 1 && mSclF == 1 && mPrevSda == 1 && mSdaF == 0);
      eStop  = (mPrevScl == 1 && mSclF == 1 && mPrevSda == 0 && mSdaF == 1);
      chk("R1", "sclFilt", int'(sclFilt), mSclF);
      chk("R1", "sdaFilt", int'(sdaFilt), mSdaF);
      chk("R3", "startStrobe", int'(startStrobe), eStart);
      chk("R3", "stopStrobe", int'(stopStrobe), eStop);
      chk("R6", "timeoutRst", int'(timeoutRst), mTmo);
      chk("R8", "sdaDriveLow", int'(sdaDriveLow), int'(slaveSdaLow) & (1 - mReleased));
      if (timeoutRst) tmoCount++;
      if (startStrobe) startCount++;
      if (!sdaFilt) sdaLowSeen = 1'b1;
    end
  end

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sclBit(int lowLen, int highLen, logic sdaVal, logic drive);
    sclIn = 1'b0;
    waitCyc(8);
    sdaIn = sdaVal;
    slaveSdaLow = drive;
    waitCyc(lowLen - 8);
    sclIn = 1'b1;
    waitCyc(highLen);
  endtask

  initial begin
    waitCyc(5);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    chk("R9", "reset sclFilt", int'(sclFilt), 1);
    chk("R9", "reset sdaFilt", int'(sdaFilt), 1);
    chk("R9", "reset timeoutRst", int'(timeoutRst), 0);
    chk("R9", "reset strobes", int'(startStrobe) + int'(stopStrobe), 0);

    // R4: long SCL low on an idle bus
    sclIn = 1'b0;
    waitCyc(3 * TMO);
    chk("R4", "idle low pulses", tmoCount, 0);
    sclIn = 1'b1;
    waitCyc(20);

    // R2: short SDA spike with SCL high
    sdaIn = 1'b0; waitCyc(FILT - 2); sdaIn = 1'b1;
    waitCyc(20);
    chk("R2", "spike on sdaFilt", int'(sdaLowSeen), 0);
    chk("R2", "spike start count", startCount, 0);

    // START, then clocking with low phases just under the limit (R5)
    sdaIn = 1'b0; waitCyc(20);
    chk("R3", "start count", startCount, 1);
    for (int i = 0; i < 8; i++) sclBit(TMO - 40, 30, logic'(i % 2), logic'((i / 2) % 2));
    chk("R5", "bursts under limit", tmoCount, 0);

    // Repeated START while open, then stall (R7, R6)
    sclIn = 1'b0; slaveSdaLow = 1'b0; waitCyc(10);
    sdaIn = 1'b1; waitCyc(20);
    sclIn = 1'b1; waitCyc(20);
    sdaIn = 1'b0; waitCyc(20);
    chk("R7", "repeated start seen", startCount, 2);
    slaveSdaLow = 1'b1;
    sclIn = 1'b0;
    waitCyc(TMO + 60);
    chk("R6", "one pulse after stall", tmoCount, 1);
    chk("R7", "sda released after timeout", int'(sdaDriveLow), 0);
    sclIn = 1'b1; waitCyc(20);
    sclIn = 1'b0; waitCyc(2 * TMO);
    chk("R7", "no rearm without start", tmoCount, 1);
    chk("R7", "still released", int'(sdaDriveLow), 0);

    // STOP then fresh START clears the release
    sclIn = 1'b1; waitCyc(20);
    sdaIn = 1'b1; waitCyc(20);
    sdaIn = 1'b0; waitCyc(20);
    chk("R7", "start lifts release", int'(sdaDriveLow), 1);
    slaveSdaLow = 1'b0;

    // R5: a genuine high phase restarts the measurement
    sclIn = 1'b0; waitCyc(TMO - 60);
    sclIn = 1'b1; waitCyc(10);
    sclIn = 1'b0; waitCyc(TMO - 60);
    chk("R5", "split low no timeout", tmoCount, 1);

    // R2: a spike on SCL does not restart the measurement
    sclIn = 1'b1; waitCyc(FILT - 2);
    sclIn = 1'b0; waitCyc(80);
    chk("R2", "scl spike ignored by timer", tmoCount, 2);

    // close the bus
    sclIn = 1'b1; waitCyc(20);
    sdaIn = 1'b1; waitCyc(20);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule